// File: doc/BRIEF.md
# I2C Master SCL Phase Timer

This block times the low and high halves of the SCL waveform for an I2C master, counting system clocks. Software writes one configuration word that holds a low-phase divider, a high-phase divider and a power-of-two prescaler exponent. From that word the block derives how long each phase lasts. The length of a phase is the divider shifted left by the exponent, plus a fixed number of system clocks. That fixed number is set by a parameter.

The bit engine that drives the bus reads `scl_o` as the level to present. It also reads two one-cycle strobes, one at the start of each phase. A target device that is stretching the clock asserts `hold`. While `hold` is high during the high phase, the count pauses. A new configuration word is picked up only when a phase starts, so a phase that is running is never cut short or stretched by a write. While `en` is low, SCL stays high and the counting state is cleared.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, `scl_o` is 1 and both `low_start` and `high_start` are 0.
- R2: While `en` is low, `scl_o` is 1 and neither strobe fires. Enabling again always begins with a full low phase.
- R3: A low phase lasts low_div × 2^e + OFFSET system clocks, with `scl_o` at 0. A divider of 0 gives a phase of exactly OFFSET clocks.
- R4: A high phase lasts high_div × 2^e + OFFSET system clocks, with `scl_o` at 1.
- R5: If the written exponent field is larger than MAX_EXP, the value MAX_EXP is used in its place.
- R6: The configuration word places low_div in bits [7:0], high_div in bits [15:8] and the exponent e in bits [18:16]. `cfg_we` captures it at a clock edge.
- R7: Each clock edge at which `hold` is 1 during a high phase adds one cycle to that phase. `hold` has no effect during a low phase.
- R8: A configuration write that lands during a phase leaves that phase's length unchanged. The write sets the length of every phase that starts after it.
- R9: `low_start` is 1 for exactly the cycle in which `scl_o` has just fallen. `high_start` is 1 only in a cycle in which `scl_o` has just risen.
- R10: Suppose `en` is first seen high at a clock edge while the block is idle. Then `scl_o` falls and `low_start` pulses at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds SCL high and clears the counters |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 19 | Configuration word: low divider, high divider, exponent |
| hold | input | 1 | Clock stretch request; pauses the high phase |
| scl_o | output | 1 | Registered SCL level |
| low_start | output | 1 | One-cycle strobe marking the start of a low phase |
| high_start | output | 1 | One-cycle strobe marking the start of a high phase |

## Verification
All outputs are registered, so each stimulus is judged at a known edge. An enable seen at one edge shows up as `scl_o` low and `low_start` high at the falling clock half that follows. A configuration write becomes visible one edge later, and the bench does not expect it to change anything before the next phase start. For that reason, each length check waits for two fresh low-phase starts after the write. Phase lengths are counted at falling clock edges, as the runs between level changes of `scl_o`. Hold stimulus is applied for a counted number of edges, and the expected phase length grows by exactly that number.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 5,
  localparam int CFG_W  = 2 * DIV_W + EXP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [DIV_W-1:0] low_div,
  output logic [DIV_W-1:0] high_div,
  output logic [EXP_W-1:0] exp_q
);
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(MAX_EXP);

  logic [EXP_W-1:0] exp_field;
  assign exp_field = wdata[2*DIV_W +: EXP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      low_div  <= '0;
      high_div <= '0;
      exp_q    <= '0;
    end else if (we) begin
      low_div  <= wdata[0 +: DIV_W];
      high_div <= wdata[DIV_W +: DIV_W];
      exp_q    <= (exp_field > EXP_CAP) ? EXP_CAP : exp_field;
    end
  end

  // R5: stored exponent never exceeds the cap
  p_exp_cap_r5: assert property (@(posedge clk) disable iff (rst)
    exp_q <= EXP_CAP);
endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
  parameter int DIV_W  = 8,
  parameter int EXP_W  = 3,
  parameter int OFFSET = 4,
  parameter int CNT_W  = 14
) (
  input  logic [DIV_W-1:0] div,
  input  logic [EXP_W-1:0] exp_v,
  output logic [CNT_W-1:0] len_m1
);
  localparam logic [CNT_W-1:0] OFS_M1 = CNT_W'(OFFSET - 1);

  always_comb begin
    len_m1 = (CNT_W'(div) << exp_v) + OFS_M1;
  end
endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_timer_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hold,
  input  logic [CNT_W-1:0] low_len_m1,
  input  logic [CNT_W-1:0] high_len_m1,
  output logic             scl_o,
  output logic             low_start,
  output logic             high_start
);
  scl_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      scl_o      <= 1'b1;
      low_start  <= 1'b0;
      high_start <= 1'b0;
    end else begin
      low_start  <= 1'b0;
      high_start <= 1'b0;
      case (phase)
        PH_IDLE: begin
          phase     <= PH_LOW;
          cnt       <= low_len_m1;
          scl_o     <= 1'b0;
          low_start <= 1'b1;
        end
        PH_LOW: begin
          if (cnt_zero) begin
            phase      <= PH_HIGH;
            cnt        <= high_len_m1;
            scl_o      <= 1'b1;
            high_start <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (!hold) begin
            if (cnt_zero) begin
              phase     <= PH_LOW;
              cnt       <= low_len_m1;
              scl_o     <= 1'b0;
              low_start <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
          scl_o <= 1'b1;
        end
      endcase
    end
  end

  // R2: disabled means SCL released high on the next edge
  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_o && !low_start && !high_start));

  // R3: a low phase with count remaining stays low
  p_low_runs_r3: assert property (@(posedge clk) disable iff (rst)
    (en && phase == PH_LOW && !cnt_zero) |=> (phase == PH_LOW && !scl_o));

  // R7: stretching freezes the high phase counter
  p_hold_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (en && phase == PH_HIGH && hold) |=> (phase == PH_HIGH && $stable(cnt) && scl_o));

  // R9: strobes never coincide, and a falling SCL always carries low_start
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(low_start && high_start));
  p_fall_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_o) |-> low_start);

  // R10: enable from idle starts the low phase at once
  p_start_low_r10: assert property (@(posedge clk) disable iff (rst)
    (en && phase == PH_IDLE) |=> (!scl_o && low_start));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 5,
  parameter int OFFSET  = 4,
  localparam int CFG_W  = 2 * DIV_W + EXP_W,
  localparam int CNT_W  = DIV_W + MAX_EXP + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             hold,
  output logic             scl_o,
  output logic             low_start,
  output logic             high_start
);
  logic [DIV_W-1:0] div_sel [2];
  logic [CNT_W-1:0] len_m1  [2];
  logic [EXP_W-1:0] exp_v;

  scl_cfg_reg #(
    .DIV_W  (DIV_W),
    .EXP_W  (EXP_W),
    .MAX_EXP(MAX_EXP)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .low_div (div_sel[0]),
    .high_div(div_sel[1]),
    .exp_q   (exp_v)
  );

  for (genvar g = 0; g < 2; g++) begin : g_len
    scl_phase_len #(
      .DIV_W (DIV_W),
      .EXP_W (EXP_W),
      .OFFSET(OFFSET),
      .CNT_W (CNT_W)
    ) u_len (
      .div   (div_sel[g]),
      .exp_v (exp_v),
      .len_m1(len_m1[g])
    );
  end

  scl_phase_ctl #(
    .CNT_W(CNT_W)
  ) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .hold       (hold),
    .low_len_m1 (len_m1[0]),
    .high_len_m1(len_m1[1]),
    .scl_o      (scl_o),
    .low_start  (low_start),
    .high_start (high_start)
  );
endmodule

// File: tb/tb_i2c_scl_timer.sv
module tb_i2c_scl_timer;
  localparam int OFS  = 4;
  localparam int MAXE = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [18:0] cfg_wdata = '0;
  logic        hold = 1'b0;
  logic        scl_o, low_start, high_start;

  int tests = 0;
  int fails = 0;
  int last_low = 0;
  int last_high = 0;
  int run = 0;
  int strobe_bad = 0;
  logic prev_scl = 1'b1;

  i2c_scl_timer dut (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .hold(hold), .scl_o(scl_o), .low_start(low_start), .high_start(high_start)
  );

  always #4 clk = ~clk;

  function automatic int plen(int d, int e);
    int ee;
    ee = (e > MAXE) ? MAXE : e;
    return d * (1 << ee) + OFS;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      prev_scl = 1'b1;
      run = 0;
    end else begin
      if (scl_o != prev_scl) begin
        if (prev_scl == 1'b0) last_low = run;
        else last_high = run;
        run = 1;
      end else begin
        run++;
      end
      if ((low_start != (prev_scl && !scl_o)) || (high_start && !(!prev_scl && scl_o)))
        strobe_bad++;
      prev_scl = scl_o;
    end
  end

  task automatic write_cfg(int lo, int hi, int e);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {3'(e), 8'(hi), 8'(lo)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_ls();
    do begin @(negedge clk); #1; end while (!low_start);
  endtask

  task automatic wait_hs();
    do begin @(negedge clk); #1; end while (!high_start);
  endtask

  task automatic measure(int lo, int hi, int e, string tag);
    wait_ls();
    wait_ls();
    chk(last_low == plen(lo, e), {tag, " low"}, last_low, plen(lo, e));
    chk(last_high == plen(hi, e), {tag, " high"}, last_high, plen(hi, e));
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int idle_bad;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(scl_o == 1'b1 && !low_start && !high_start, "R1 reset",
        {scl_o, low_start, high_start}, 3'b100);
    rst = 1'b0;
    write_cfg(2, 5, 1);
    @(negedge clk);
    en = 1'b1;
    // R10: first edge with en starts the low phase
    @(negedge clk);
    chk(!scl_o && low_start, "R10 start", {scl_o, low_start}, 2'b01);
    // R6 field layout, R3 and R4 lengths
    measure(2, 5, 1, "R6 R3 R4 directed");
    // R3 zero divider gives only the offset
    write_cfg(0, 0, 3);
    measure(0, 0, 3, "R3 zero div");
    // R5 exponent saturation
    write_cfg(1, 2, 7);
    measure(1, 2, 7, "R5 sat");
    // R3 R4 random patterns
    for (int i = 0; i < 8; i++) begin
      int lo, hi, e;
      lo = int'($urandom % 16);
      hi = int'($urandom % 16);
      e  = int'($urandom % 4);
      write_cfg(lo, hi, e);
      measure(lo, hi, e, "R3 R4 random");
    end
    // R7 hold stretches the high phase
    write_cfg(3, 4, 1);
    wait_ls();
    wait_hs();
    hold = 1'b1;
    repeat (5) @(negedge clk);
    hold = 1'b0;
    wait_ls();
    chk(last_high == plen(4, 1) + 5, "R7 stretch", last_high, plen(4, 1) + 5);
    // R7 hold ignored during low
    wait_ls();
    hold = 1'b1;
    repeat (5) @(negedge clk);
    hold = 1'b0;
    wait_hs();
    chk(last_low == plen(3, 1), "R7 low ignore", last_low, plen(3, 1));
    // R8 mid-phase write waits for the boundary
    write_cfg(6, 6, 1);
    wait_ls();
    wait_ls();
    repeat (2) @(negedge clk);
    write_cfg(1, 1, 0);
    wait_hs();
    chk(last_low == plen(6, 1), "R8 current low kept", last_low, plen(6, 1));
    wait_ls();
    chk(last_high == plen(1, 0), "R8 next high new", last_high, plen(1, 0));
    // R2 disabled state
    write_cfg(5, 2, 1);
    repeat (3) @(negedge clk);
    en = 1'b0;
    idle_bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (!scl_o || low_start || high_start) idle_bad++;
    end
    chk(idle_bad == 0, "R2 idle", idle_bad, 0);
    en = 1'b1;
    @(negedge clk);
    chk(!scl_o && low_start, "R10 restart", {scl_o, low_start}, 2'b01);
    wait_hs();
    chk(last_low == plen(5, 1), "R2 full low after enable", last_low, plen(5, 1));
    wait_ls();
    // R9 strobe alignment over the whole run
    chk(strobe_bad == 0, "R9 strobes", strobe_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule